// File: doc/BRIEF.md
# Dual-Channel Disk Register Window Decoder

This block sits between a host I/O port and the register files of a two-channel disk controller. Every I/O access (address, size, direction, write data) is matched against five programmable windows. There is a command window and a control window for each of the two channels, and there is one bus-master register window. The result is one decoded request that carries the window kind, a channel flag, the offset inside the window and a two-bit drive index. The drive register files and the DMA engine consume that request downstream.

The decoder watches command-window writes to the drive/head select register. From them it keeps one master/slave bit per channel, so later drive-register traffic is steered to the device that software last selected. The bus-master window is split into a primary half and a secondary half by offset. Writes into that window are discarded without any report while the bus-master enable input is low. Window bases are changed through a simple load strobe.

Requests enter on a valid/ready stream and leave on a valid/ready stream through a single output register. An access is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or the consumer is taking its content in the same cycle. `out_valid` and all `out_*` payload fields hold unchanged while `out_ready` is low. The error flag is a plain one-cycle pulse.

Top module: `ide_window_decoder`

## Requirements
- R1: Hits in a command window are reported with kind 1, hits in a control window with kind 2, and hits in the bus-master window with kind 3. The offset is the access address minus the base of the window that was hit. A window spans from its base through base+span-1, with spans of 8 (command), 4 (control) and 16 (bus-master) by default.
- R2: When windows overlap, the lowest-numbered window wins. The order is primary command (0), primary control (1), secondary command (2), secondary control (3), bus-master (4).
- R3: `out_primary` is 1 for windows 0 and 1 and 0 for windows 2 and 3. In the bus-master window it is 1 for offsets below 8 and 0 for offsets 8 to 15.
- R4: A legal write to offset 6 of a command window loads bit 4 of the write data into that channel's device bit (1 = slave, 0 = master). The drive index is {secondary, device bit}, where secondary = !out_primary. The select write itself already carries the newly written bit.
- R5: After reset both device bits are 0, so primary traffic carries drive 0 and secondary traffic carries drive 2.
- R6: `req_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = illegal. A 4-byte access is legal only in the bus-master window.
- R7: A taken access that misses every window or has an illegal size raises `err` for exactly the following cycle. It produces no output and leaves the device bits unchanged. This error check takes precedence over R8.
- R8: A bus-master-window write taken while `bm_enable` is 0 produces no output and no error. A bus-master read in the same condition is forwarded.
- R9: A base load with a nonzero value replaces the selected window base from the next access on. A load of zero, or a `base_sel` above 4, leaves every base unchanged.
- R10: `req_ready` equals !out_valid || out_ready. While `out_valid` is high and `out_ready` is low, the output and all its fields hold stable.
- R11: Out of reset, `out_valid` and `err` are 0 and the bases take their parameter defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bm_enable | input | 1 | Bus-master enable; 0 drops bus-master writes |
| base_load | input | 1 | Base load strobe |
| base_sel | input | 3 | Window to load (0..4) |
| base_value | input | ADDR_W | New base; zero is ignored |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request can be taken |
| req_addr | input | ADDR_W | Access address |
| req_size | input | 2 | 0=1B, 1=2B, 2=4B, 3=illegal |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| out_valid | output | 1 | Decoded request valid |
| out_ready | input | 1 | Consumer takes the decoded request |
| out_type | output | 2 | 1=command, 2=control, 3=bus-master |
| out_primary | output | 1 | 1 = primary channel |
| out_offset | output | OFS_W | Offset inside the window |
| out_drive | output | 2 | {secondary, device bit} |
| out_write | output | 1 | Direction of the forwarded access |
| out_size | output | 2 | Size code of the forwarded access |
| out_wdata | output | DATA_W | Write data of the forwarded access |
| err | output | 1 | One-cycle pulse for a missed or illegal access |

## Verification
The hardest case to reach from the ports is a drive-select write that is taken while the output stage is stalled, followed by drive traffic on the same channel. Reaching it also needs windows that overlap, and overlap exists only after the bases are reprogrammed. The stimulus first loads a base that overlaps another window so the priority order can be observed. It then issues select writes with `out_ready` toggling in a fixed-seed pattern. After that, a long mixed phase interleaves base reloads (including zero values), `bm_enable` flips and back-pressure. A behavioural model compares every output on every clock throughout.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_CMD  = 2'd1,
    WIN_CTRL = 2'd2,
    WIN_BM   = 2'd3
  } win_kind_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  localparam int unsigned WIN_COUNT = 5;
  localparam int unsigned WIN_IDX_W = $clog2(WIN_COUNT);

  // window index -> kind; index order is also the match priority
  function automatic win_kind_e kind_of_win(input int unsigned idx);
    case (idx)
      0, 2:    return WIN_CMD;
      1, 3:    return WIN_CTRL;
      4:       return WIN_BM;
      default: return WIN_NONE;
    endcase
  endfunction

  function automatic logic win_is_primary(input int unsigned idx);
    return (idx == 0) || (idx == 1);
  endfunction

endpackage

// File: rtl/ide_win_match.sv
module ide_win_match #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 4,
  parameter int SPAN   = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [OFS_W-1:0]  ofs_o
);

  logic [ADDR_W:0]   limit;
  logic [ADDR_W-1:0] diff;

  always_comb begin
    limit = {1'b0, base_i} + (ADDR_W+1)'(SPAN);
    hit_o = ({1'b0, addr_i} >= {1'b0, base_i}) && ({1'b0, addr_i} < limit);
    diff  = addr_i - base_i;
    ofs_o = diff[OFS_W-1:0];
  end

  // range compare and subtraction are separate paths; they must agree
  always_comb begin
    if (hit_o) begin
      assert_ofs_in_span_R1: assert (diff < ADDR_W'(SPAN));
    end
  end

endmodule

// File: rtl/ide_base_bank.sv
module ide_base_bank #(
  parameter int ADDR_W = 16,
  parameter int WIN_N  = 5,
  parameter int SEL_W  = 3,
  parameter logic [WIN_N*ADDR_W-1:0] RESET_BASES = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_i,
  input  logic [SEL_W-1:0]             sel_i,
  input  logic [ADDR_W-1:0]            value_i,
  output logic [WIN_N-1:0][ADDR_W-1:0] base_o
);

  logic nonzero;
  assign nonzero = (value_i != '0);

  for (genvar g = 0; g < WIN_N; g++) begin : g_base
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_o[g] <= RESET_BASES[g*ADDR_W +: ADDR_W];
      end else if (load_i && nonzero && (sel_i == SEL_W'(g))) begin
        base_o[g] <= value_i;
      end
    end

    assert_zero_keeps_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && value_i == '0) |=> $stable(base_o[g]));
  end

endmodule

// File: rtl/ide_dev_shadow.sv
module ide_dev_shadow #(
  parameter int CHAN_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic              upd_ch_i,
  input  logic              upd_val_i,
  output logic [CHAN_N-1:0] dev_o
);

  for (genvar c = 0; c < CHAN_N; c++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dev_o[c] <= 1'b0;
      end else if (upd_i && (upd_ch_i == c[0])) begin
        dev_o[c] <= upd_val_i;
      end
    end

    assert_dev_only_on_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_i && upd_ch_i == c[0]) |=> $stable(dev_o[c]));
  end

endmodule

// File: rtl/ide_prio_pick.sv
module ide_prio_pick #(
  parameter int N     = 5,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     hit_i,
  output logic [N-1:0]     sel_oh_o,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    sel_oh_o = '0;
    idx_o    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        sel_oh_o    = '0;
        sel_oh_o[i] = 1'b1;
        idx_o       = IDX_W'(i);
      end
    end
    any_o = |hit_i;
  end

endmodule

// File: rtl/ide_window_decoder.sv
module ide_window_decoder
  import ide_dec_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int CMD_SPAN   = 8,
  parameter int CTRL_SPAN  = 4,
  parameter int BM_SPAN    = 16,
  parameter int BM_SEC_OFS = 8,
  parameter int SEL_OFS    = 6,
  parameter int DEV_BIT    = 4,
  parameter logic [ADDR_W-1:0] PRI_CMD_BASE  = 16'h01F0,
  parameter logic [ADDR_W-1:0] PRI_CTRL_BASE = 16'h03F4,
  parameter logic [ADDR_W-1:0] SEC_CMD_BASE  = 16'h0170,
  parameter logic [ADDR_W-1:0] SEC_CTRL_BASE = 16'h0374,
  parameter logic [ADDR_W-1:0] BM_BASE       = 16'hC000,
  localparam int MAX_SPAN = (BM_SPAN > CMD_SPAN) ?
                            ((BM_SPAN > CTRL_SPAN) ? BM_SPAN : CTRL_SPAN) :
                            ((CMD_SPAN > CTRL_SPAN) ? CMD_SPAN : CTRL_SPAN),
  localparam int OFS_W = (MAX_SPAN > 1) ? $clog2(MAX_SPAN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bm_enable,
  input  logic              base_load,
  input  logic [2:0]        base_sel,
  input  logic [ADDR_W-1:0] base_value,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_type,
  output logic              out_primary,
  output logic [OFS_W-1:0]  out_offset,
  output logic [1:0]        out_drive,
  output logic              out_write,
  output logic [1:0]        out_size,
  output logic [DATA_W-1:0] out_wdata,
  output logic              err
);

  localparam int NW = WIN_COUNT;
  localparam logic [NW*ADDR_W-1:0] RESET_BASES =
    {BM_BASE, SEC_CTRL_BASE, SEC_CMD_BASE, PRI_CTRL_BASE, PRI_CMD_BASE};

  function automatic int span_of(input int idx);
    if (idx == 4) return BM_SPAN;
    if (idx == 1 || idx == 3) return CTRL_SPAN;
    return CMD_SPAN;
  endfunction

  // ---------------- window bases ----------------
  logic [NW-1:0][ADDR_W-1:0] base;

  ide_base_bank #(
    .ADDR_W(ADDR_W), .WIN_N(NW), .SEL_W(3), .RESET_BASES(RESET_BASES)
  ) u_bases (
    .clk(clk), .rst_n(rst_n), .load_i(base_load), .sel_i(base_sel),
    .value_i(base_value), .base_o(base)
  );

  // ---------------- per-window range match ----------------
  logic [NW-1:0]            hit;
  logic [NW-1:0][OFS_W-1:0] ofs;

  for (genvar g = 0; g < NW; g++) begin : g_win
    ide_win_match #(
      .ADDR_W(ADDR_W), .OFS_W(OFS_W), .SPAN(span_of(g))
    ) u_match (
      .base_i(base[g]), .addr_i(req_addr), .hit_o(hit[g]), .ofs_o(ofs[g])
    );
  end

  // ---------------- priority selection ----------------
  logic [NW-1:0]        sel_oh;
  logic                 any_hit;
  logic [WIN_IDX_W-1:0] win_idx;

  ide_prio_pick #(.N(NW), .IDX_W(WIN_IDX_W)) u_pick (
    .hit_i(hit), .sel_oh_o(sel_oh), .any_o(any_hit), .idx_o(win_idx)
  );

  // ---------------- access classification ----------------
  win_kind_e        cur_kind;
  logic [OFS_W-1:0] cur_ofs;
  logic             cur_primary;
  logic             size_bad;
  logic             acc_bad;
  logic             bm_drop;
  logic             accept;
  logic             sel_write;
  logic             chan_sec;
  logic             dev_eff;
  logic [1:0]       dev_bits;

  assign req_ready = !out_valid || out_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    cur_ofs  = ofs[win_idx];
    cur_kind = any_hit ? kind_of_win(32'(win_idx)) : WIN_NONE;
    if (cur_kind == WIN_BM) begin
      cur_primary = (cur_ofs < OFS_W'(BM_SEC_OFS));
    end else begin
      cur_primary = win_is_primary(32'(win_idx));
    end
    size_bad  = (req_size == SZ_BAD) ||
                ((req_size == SZ_WORD) && (cur_kind != WIN_BM));
    acc_bad   = !any_hit || size_bad;
    bm_drop   = (cur_kind == WIN_BM) && req_write && !bm_enable;
    sel_write = accept && !acc_bad && req_write &&
                (cur_kind == WIN_CMD) && (cur_ofs == OFS_W'(SEL_OFS));
    chan_sec  = !cur_primary;
    dev_eff   = sel_write ? req_wdata[DEV_BIT] : dev_bits[chan_sec];
  end

  // ---------------- drive-select shadow ----------------
  ide_dev_shadow #(.CHAN_N(2)) u_shadow (
    .clk(clk), .rst_n(rst_n), .upd_i(sel_write), .upd_ch_i(chan_sec),
    .upd_val_i(req_wdata[DEV_BIT]), .dev_o(dev_bits)
  );

  // ---------------- output stage ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      err       <= 1'b0;
    end else begin
      err <= accept && acc_bad;
      if (accept) begin
        out_valid <= !acc_bad && !bm_drop;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_type    <= WIN_NONE;
      out_primary <= 1'b0;
      out_offset  <= '0;
      out_drive   <= '0;
      out_write   <= 1'b0;
      out_size    <= '0;
      out_wdata   <= '0;
    end else if (accept && !acc_bad && !bm_drop) begin
      out_type    <= cur_kind;
      out_primary <= cur_primary;
      out_offset  <= cur_ofs;
      out_drive   <= {chan_sec, dev_eff};
      out_write   <= req_write;
      out_size    <= req_size;
      out_wdata   <= req_wdata;
    end
  end

  // ---------------- assertions ----------------
  assert_single_winner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh));

  assert_kind_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_type != WIN_NONE));

  assert_no_word_on_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_type != WIN_BM) |-> (out_size != SZ_WORD));

  assert_bad_not_forwarded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && acc_bad) |=> (err && !out_valid));

  assert_bm_write_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !acc_bad && cur_kind == WIN_BM && req_write && !bm_enable)
      |=> (!out_valid && !err));

  assert_hold_under_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_offset) &&
      $stable(out_type) && $stable(out_drive) && $stable(out_wdata)));

endmodule

// File: tb/ide_window_decoder_tb_top.sv
module ide_window_decoder_tb_top;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int OFS_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bm_enable = 1'b0;
  logic              base_load = 1'b0;
  logic [2:0]        base_sel = '0;
  logic [ADDR_W-1:0] base_value = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_size = '0;
  logic              req_write = 1'b0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [1:0]        out_type;
  logic              out_primary;
  logic [OFS_W-1:0]  out_offset;
  logic [1:0]        out_drive;
  logic              out_write;
  logic [1:0]        out_size;
  logic [DATA_W-1:0] out_wdata;
  logic              err;

  always #10 clk = ~clk;   // 50 MHz

  ide_window_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .bm_enable(bm_enable), .base_load(base_load),
    .base_sel(base_sel), .base_value(base_value), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_size(req_size),
    .req_write(req_write), .req_wdata(req_wdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_type(out_type), .out_primary(out_primary),
    .out_offset(out_offset), .out_drive(out_drive), .out_write(out_write),
    .out_size(out_size), .out_wdata(out_wdata), .err(err)
  );

  int compared = 0;
  int mismatched = 0;
  bit bp_on = 0;
  bit done = 0;

  // ---------------- behavioural reference ----------------
  int  def_base[5] = '{'h01F0, 'h03F4, 'h0170, 'h0374, 'hC000};
  int  m_base[5];
  int  span[5] = '{8, 4, 8, 4, 16};
  int  kind[5] = '{1, 2, 1, 2, 3};
  bit  m_dev[2];
  bit  m_valid, m_err, m_acc, m_prim, m_write;
  int  m_type, m_ofs, m_drive, m_size;
  logic [DATA_W-1:0] m_wdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) m_base[i] = def_base[i];
      m_dev = '{0, 0}; m_valid = 0; m_err = 0; m_acc = 0;
      m_type = 0; m_ofs = 0; m_drive = 0; m_size = 0; m_prim = 0; m_write = 0; m_wdata = '0;
    end else begin
      int w, o, ch;
      bit pr, bad;
      m_acc = req_valid && (!m_valid || out_ready);
      m_err = 0;
      if (m_acc) begin
        w = -1; o = 0;
        for (int i = 0; i < 5; i++)
          if (w < 0 && int'(req_addr) >= m_base[i] && int'(req_addr) < m_base[i] + span[i]) begin
            w = i; o = int'(req_addr) - m_base[i];
          end
        bad = (w < 0) || (req_size == 3) || (req_size == 2 && w != 4);
        if (bad) begin
          m_err = 1; m_valid = 0;
        end else if (w == 4 && req_write && !bm_enable) begin
          m_valid = 0;
        end else begin
          pr = (w == 4) ? (o < 8) : (w < 2);
          ch = pr ? 0 : 1;
          if (kind[w] == 1 && req_write && o == 6) m_dev[ch] = req_wdata[4];
          m_valid = 1; m_type = kind[w]; m_ofs = o; m_prim = pr;
          m_drive = ch * 2 + int'(m_dev[ch]);
          m_write = req_write; m_size = int'(req_size); m_wdata = req_wdata;
        end
      end else if (out_ready) begin
        m_valid = 0;
      end
      if (base_load && base_sel < 5 && base_value != 0) m_base[base_sel] = int'(base_value);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // compare every clock, a quarter period after the edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk(req_ready == (!m_valid || out_ready), "R10 req_ready", req_ready, !m_valid || out_ready);
      chk(out_valid == m_valid, "R7/R8 out_valid", out_valid, m_valid);
      chk(err == m_err, "R7 err", err, m_err);
      if (m_valid) begin
        chk(int'(out_type) == m_type, "R1/R2 type", out_type, m_type);
        chk(int'(out_offset) == m_ofs, "R1 offset", out_offset, m_ofs);
        chk(out_primary == m_prim, "R3 primary", out_primary, m_prim);
        chk(int'(out_drive) == m_drive, "R4/R5 drive", out_drive, m_drive);
        chk(int'(out_size) == m_size && out_write == m_write, "R6 size/dir",
            {out_size, out_write}, {m_size[1:0], m_write});
        chk(out_wdata == m_wdata, "R10 wdata", out_wdata, m_wdata);
      end
    end
  end

  // back-pressure pattern
  initial forever begin
    @(negedge clk);
    out_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  task automatic send(input int addr, input int sz, input bit wr, input int data);
    @(negedge clk);
    base_load = 0;
    req_valid = 1; req_addr = ADDR_W'(addr); req_size = 2'(sz);
    req_write = wr; req_wdata = DATA_W'(data);
    do begin
      @(posedge clk); #1;
    end while (!m_acc);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 0; base_load = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input int sel, input int val);
    @(negedge clk);
    req_valid = 0;
    base_load = 1; base_sel = 3'(sel); base_value = ADDR_W'(val);
    @(negedge clk);
    base_load = 0;
  endtask

  // watchdog
  initial begin
    #(20 * 150000);
    mismatched++; compared++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(out_valid == 0 && err == 0, "R11 reset outputs", {out_valid, err}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R11 ready after reset", req_ready, 1);

    // R5: device bits start at master; R1/R3 every window, edges of span
    for (int w = 0; w < 5; w++) begin
      send(def_base[w], 0, 0, 0);
      send(def_base[w] + span[w] - 1, 1, 0, 0);
    end
    // R3 bus-master split around offset 8
    for (int o = 6; o < 10; o++) send('hC000 + o, 0, 0, 0);
    // R7 misses just outside windows
    send('h01EF, 0, 0, 0);
    send('h01F8, 0, 0, 0);
    // R6 sizes: word to drive window, illegal code, word to bus-master
    send('h01F0, 2, 0, 0);
    send('hC004, 3, 0, 0);
    send('hC004, 2, 0, 'h1234);
    // R4 select writes steer the drive index, including the select write itself
    send('h01F6, 0, 1, 'h10);
    send('h01F0, 1, 0, 0);
    send('h0176, 0, 1, 'h10);
    send('h0172, 0, 1, 'h55);
    send('h0176, 0, 1, 'hEF);
    send('h0170, 0, 0, 0);
    // R4 an illegal-size select write must not touch the bit (R7)
    send('h01F6, 2, 1, 'h00);
    send('h01F0, 0, 0, 0);
    // R8 bus-master writes while disabled, then read, then enabled
    bm_enable = 0;
    send('hC002, 0, 1, 'hAA);
    send('hC002, 0, 0, 0);
    bm_enable = 1;
    send('hC002, 0, 1, 'hAA);
    idle(2);
    // R9 zero load ignored, nonzero load moves the window
    load(1, 0);
    send('h03F4, 0, 0, 0);
    load(3, 'h0400);
    send('h0400, 0, 0, 0);
    send('h0374, 0, 0, 0);
    load(6, 'h1000);
    send('h1000, 0, 0, 0);
    // R2 overlap: primary control moved inside primary command
    load(1, 'h01F4);
    send('h01F5, 0, 0, 0);
    send('h01F8, 0, 0, 0);
    // R10 stream under back-pressure, select writes while stalled
    bp_on = 1;
    for (int k = 0; k < 40; k++) send('h01F6 - 6 * (k % 2) + (k % 8), k % 2, k % 3 == 0, k * 16);
    // mixed traffic with base reloads and enable flips
    for (int k = 0; k < 3000; k++) begin
      int w, a;
      w = $urandom_range(0, 5);
      if (w == 5) a = $urandom_range(0, 'hFFFF);
      else a = m_base[w] + $urandom_range(0, span[w] + 1) - 1;
      if ($urandom_range(0, 60) == 0) load($urandom_range(0, 5),
          ($urandom_range(0, 2) == 0) ? 0 : def_base[$urandom_range(0, 4)] + $urandom_range(0, 6));
      if ($urandom_range(0, 30) == 0) bm_enable = ~bm_enable;
      if ($urandom_range(0, 10) == 0) idle($urandom_range(0, 3));
      send(a & 'hFFFF, $urandom_range(0, 3), $urandom_range(0, 1) == 1, int'($urandom));
    end
    bp_on = 0;
    idle(5);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule